// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block holds a small bank of address-match triggers for a processor's debug path. Software reaches it through three register-style locations: a selector that picks one trigger, a control word for that trigger, and a compare value for that trigger. Each trigger looks at every access the core reports. The access can be an instruction fetch, a load or a store. A trigger fires when its enable bit for that kind of access is set, the current privilege level is allowed, and the access address equals the compare value exactly. When any trigger fires, the unit raises a breakpoint-exception pulse in the same cycle and reports which trigger fired.

The control word uses a legacy layout. The trigger type sits in the top four bits and always reads 1. Settings the unit does not support are dropped when written, so software can write a word, read it back and compare the two to learn whether the trigger accepted the setting. To count the triggers, software writes increasing indices to the selector. A write past the last trigger leaves the index where it was, so the read-back no longer matches what was written. The selector's most significant bit is a separate mode flag that is kept apart from the index.

Top module: `brk_trig_unit`

## Requirements
- R1: After reset, every control word reads as the type field alone (value 1 in bits XLEN-1:XLEN-4, all other bits 0), every compare value reads 0, the selector reads 0, and no breakpoint is raised.
- R2: In the control word, bit 0 enables execute matching, bit 1 enables store matching, bit 2 enables load matching, and bits 3, 4, 5 and 6 enable user, supervisor, hypervisor and machine privilege. Bits 0-4 and 6 read back as written. Bit 5 reads back as written only when HAS_HYP is 1 and otherwise reads 0.
- R3: The match-mode field (bits 10:7) and the action field (bits 18:11) accept only 0, meaning exact match and breakpoint exception. Any other value written reads back as 0, and so do bits 19 to XLEN-5. The type field (top 4 bits) always reads 1.
- R4: A valid snoop raises bkpt_hit combinationally in the same cycle when the enable bit for its kind is set, the bit for its privilege is set, and its address equals the trigger's compare value. Kind is coded 0 execute, 1 store, 2 load, 3 none. Privilege is coded 0 user, 1 supervisor, 2 hypervisor, 3 machine.
- R5: When several triggers match, bkpt_idx reports the lowest-numbered one.
- R6: A trigger's control word and compare value change only on a write to that location while that trigger is selected. Writes aimed at other triggers leave them unchanged.
- R7: A selector write whose low XLEN-1 bits are greater than or equal to NUM_TRIG leaves the index unchanged, so the read-back differs from the value written.
- R8: The selector's bit XLEN-1 is a separate mode flag. It is stored and read back on every selector write and does not take part in picking the trigger.
- R9: Writing zero to a control word disables that trigger, so it raises no further hits.
- R10: With snp_valid low, or snp_kind 3, no breakpoint is raised. The compare value reads back exactly as written. Register address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 selector, 1 control, 2 compare, 3 unused |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data, combinational from csr_addr |
| snp_valid | input | 1 | Snooped access is valid this cycle |
| snp_kind | input | 2 | Access kind: 0 execute, 1 store, 2 load, 3 none |
| snp_priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| snp_addr | input | XLEN | Access address |
| bkpt_hit | output | 1 | Breakpoint exception pulse |
| bkpt_idx | output | IDX_W | Lowest-numbered matching trigger |

## Verification
The bench builds the unit with its defaults: four triggers, 32-bit words and no hypervisor support. With four triggers, selector values 4 and above are out of range. That exercises the index-retention path at a boundary the bench reaches with a single write. Because the hypervisor option is off, a write of the hypervisor enable shows the legalisation in the control read-back. Two triggers share an address and two others share a second one, so the lowest-index rule can be observed against several privilege and kind combinations.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [1:0] {
      KIND_EXEC  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_LOAD  = 2'd2,
      KIND_NONE  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      PRV_USER  = 2'd0,
      PRV_SUPER = 2'd1,
      PRV_HYPER = 2'd2,
      PRV_MACH  = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      REG_SEL  = 2'd0,
      REG_CTRL = 2'd1,
      REG_CMP  = 2'd2,
      REG_NONE = 2'd3
   } reg_addr_e;

   localparam int EN_W       = 7;
   localparam int KIND_LSB   = 0;
   localparam int PRIV_LSB   = 3;
   localparam int HYP_BIT    = 5;
   localparam int TYPE_W     = 4;
   localparam logic [TYPE_W-1:0] TRIG_TYPE = 4'd1;

   typedef logic [EN_W-1:0] trig_en_t;

   function automatic trig_en_t legalise_en(input trig_en_t raw, input bit has_hyp);
      trig_en_t res;
      res = raw;
      if (!has_hyp) res[HYP_BIT] = 1'b0;
      return res;
   endfunction
endpackage

// File: rtl/trig_sel_reg.sv
module trig_sel_reg #(
   parameter int XLEN     = 32,
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [XLEN-1:0]  wdata,
   output logic [IDX_W-1:0] idx,
   output logic [XLEN-1:0]  rdata
);
   localparam logic [XLEN-2:0] LIMIT = (XLEN-1)'(NUM_TRIG);

   logic [IDX_W-1:0] idx_q;
   logic             mode_q;
   logic             in_range;

   assign in_range = (wdata[XLEN-2:0] < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         mode_q <= 1'b0;
      end else if (we) begin
         mode_q <= wdata[XLEN-1];
         if (in_range) idx_q <= wdata[IDX_W-1:0];
      end
   end

   always_comb begin
      rdata            = '0;
      rdata[IDX_W-1:0] = idx_q;
      rdata[XLEN-1]    = mode_q;
   end

   assign idx = idx_q;

   a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx_q) < NUM_TRIG);

   a_r7_out_of_range_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !in_range) |=> $stable(idx_q));

   a_r8_mode_stored: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[XLEN-1] == $past(wdata[XLEN-1])));
endmodule

// File: rtl/trig_slot.sv
module trig_slot
   import trig_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit HAS_HYP = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_we,
   input  logic            cmp_we,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] ctrl_rd,
   output logic [XLEN-1:0] cmp_rd,
   input  logic            snp_valid,
   input  logic [1:0]      snp_kind,
   input  logic [1:0]      snp_priv,
   input  logic [XLEN-1:0] snp_addr,
   output logic            hit
);
   trig_en_t        en_q;
   logic [XLEN-1:0] cmp_q;
   logic            kind_ok;
   logic            priv_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cmp_q <= '0;
      end else begin
         if (ctrl_we) en_q  <= legalise_en(wdata[EN_W-1:0], HAS_HYP);
         if (cmp_we)  cmp_q <= wdata;
      end
   end

   always_comb begin
      ctrl_rd                     = '0;
      ctrl_rd[EN_W-1:0]           = en_q;
      ctrl_rd[XLEN-1:XLEN-TYPE_W] = TRIG_TYPE;
   end

   assign cmp_rd = cmp_q;

   always_comb begin
      kind_ok = 1'b0;
      case (snp_kind)
         KIND_EXEC:  kind_ok = en_q[KIND_LSB + 0];
         KIND_STORE: kind_ok = en_q[KIND_LSB + 1];
         KIND_LOAD:  kind_ok = en_q[KIND_LSB + 2];
         default:    kind_ok = 1'b0;
      endcase
   end

   assign priv_ok = en_q[PRIV_LSB + int'(snp_priv)];
   assign hit     = snp_valid && kind_ok && priv_ok && (snp_addr == cmp_q);

   a_r9_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && (wdata[EN_W-1:0] == '0)) |=> !hit);

   a_r6_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(ctrl_rd));

   a_r6_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_we |=> $stable(cmp_rd));

   a_r2_hyp_legal: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_HYP |-> !ctrl_rd[HYP_BIT]);
endmodule

// File: rtl/trig_prio_enc.sv
module trig_prio_enc #(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit
   import trig_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NUM_TRIG = 4,
   parameter bit HAS_HYP  = 1'b0,
   parameter int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic [1:0]       csr_addr,
   input  logic [XLEN-1:0]  csr_wdata,
   output logic [XLEN-1:0]  csr_rdata,
   input  logic             snp_valid,
   input  logic [1:0]       snp_kind,
   input  logic [1:0]       snp_priv,
   input  logic [XLEN-1:0]  snp_addr,
   output logic             bkpt_hit,
   output logic [IDX_W-1:0] bkpt_idx
);
   if (NUM_TRIG < 1 || NUM_TRIG > 64) begin : g_bad_num
      $error("NUM_TRIG must be between 1 and 64");
   end
   if (XLEN < 32) begin : g_bad_xlen
      $error("XLEN must be at least 32 to hold the control layout");
   end

   logic [IDX_W-1:0] sel_idx;
   logic [XLEN-1:0]  sel_rd;
   logic [NUM_TRIG-1:0] hit_vec;
   logic [XLEN-1:0]  ctrl_rd [NUM_TRIG];
   logic [XLEN-1:0]  cmp_rd  [NUM_TRIG];
   logic             sel_we;

   assign sel_we = csr_we && (csr_addr == REG_SEL);

   trig_sel_reg #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) sel_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sel_we),
      .wdata (csr_wdata),
      .idx   (sel_idx),
      .rdata (sel_rd)
   );

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
      logic mine;
      assign mine = (sel_idx == IDX_W'(g));
      trig_slot #(.XLEN(XLEN), .HAS_HYP(HAS_HYP)) slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctrl_we   (csr_we && mine && (csr_addr == REG_CTRL)),
         .cmp_we    (csr_we && mine && (csr_addr == REG_CMP)),
         .wdata     (csr_wdata),
         .ctrl_rd   (ctrl_rd[g]),
         .cmp_rd    (cmp_rd[g]),
         .snp_valid (snp_valid),
         .snp_kind  (snp_kind),
         .snp_priv  (snp_priv),
         .snp_addr  (snp_addr),
         .hit       (hit_vec[g])
      );
   end

   trig_prio_enc #(.N(NUM_TRIG), .IDX_W(IDX_W)) enc_i (
      .req (hit_vec),
      .any (bkpt_hit),
      .idx (bkpt_idx)
   );

   always_comb begin
      case (csr_addr)
         REG_SEL:  csr_rdata = sel_rd;
         REG_CTRL: csr_rdata = ctrl_rd[sel_idx];
         REG_CMP:  csr_rdata = cmp_rd[sel_idx];
         default:  csr_rdata = '0;
      endcase
   end

   logic [NUM_TRIG-1:0] below_mask;
   assign below_mask = NUM_TRIG'((64'd1 << bkpt_idx) - 64'd1);

   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_hit |-> (hit_vec[bkpt_idx] && ((hit_vec & below_mask) == '0)));

   a_r10_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!snp_valid || snp_kind == KIND_NONE) |-> !bkpt_hit);

   a_r4_hit_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_hit |-> (hit_vec != '0));
endmodule

// File: tb/brk_trig_unit_tb_top.sv
module brk_trig_unit_tb_top;
   localparam int XLEN = 32;
   localparam int NT   = 4;
   localparam int IW   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            csr_we = 1'b0;
   logic [1:0]      csr_addr = 2'd0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic [XLEN-1:0] csr_rdata;
   logic            snp_valid = 1'b0;
   logic [1:0]      snp_kind = 2'd3;
   logic [1:0]      snp_priv = 2'd3;
   logic [XLEN-1:0] snp_addr = '0;
   logic            bkpt_hit;
   logic [IW-1:0]   bkpt_idx;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   brk_trig_unit #(.XLEN(XLEN), .NUM_TRIG(NT), .HAS_HYP(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .snp_valid(snp_valid),
      .snp_kind(snp_kind), .snp_priv(snp_priv), .snp_addr(snp_addr),
      .bkpt_hit(bkpt_hit), .bkpt_idx(bkpt_idx)
   );

   // vector: valid(1) kind(2) priv(2) addr(32) exp_hit(1) exp_idx(2)
   localparam int NV = 10;
   localparam logic [39:0] VEC [NV] = '{
      {1'b1, 2'd0, 2'd3, 32'h0000_1000, 1'b1, 2'd0},
      {1'b1, 2'd0, 2'd0, 32'h0000_1000, 1'b1, 2'd2},
      {1'b1, 2'd1, 2'd0, 32'h0000_2000, 1'b1, 2'd1},
      {1'b1, 2'd2, 2'd3, 32'h0000_2000, 1'b1, 2'd1},
      {1'b1, 2'd2, 2'd2, 32'h0000_2000, 1'b0, 2'd0},
      {1'b1, 2'd0, 2'd3, 32'h0000_1004, 1'b0, 2'd0},
      {1'b0, 2'd0, 2'd3, 32'h0000_1000, 1'b0, 2'd0},
      {1'b1, 2'd1, 2'd3, 32'h0000_1000, 1'b0, 2'd0},
      {1'b1, 2'd3, 2'd3, 32'h0000_2000, 1'b0, 2'd0},
      {1'b1, 2'd0, 2'd1, 32'h0000_1000, 1'b0, 2'd0}
   };

   task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [XLEN-1:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [XLEN-1:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic snoop(input logic v, input logic [1:0] k, input logic [1:0] p,
                        input logic [XLEN-1:0] ad, input string req,
                        input logic eh, input logic [IW-1:0] ei);
      @(negedge clk);
      snp_valid = v; snp_kind = k; snp_priv = p; snp_addr = ad;
      #1;
      check(req, {31'd0, bkpt_hit}, {31'd0, eh});
      if (eh) check(req, {30'd0, bkpt_idx}, {30'd0, ei});
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [XLEN-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1 check("R1 no hit", {31'd0, bkpt_hit}, 32'd0);
      rd(2'd0, d); check("R1 selector", d, 32'd0);
      for (int t = 0; t < NT; t++) begin
         wr(2'd0, 32'(t));
         rd(2'd1, d); check("R1 ctrl", d, 32'h1000_0000);
         rd(2'd2, d); check("R1 cmp", d, 32'd0);
      end

      // configure: t0 X|M @1000, t1 W|R|U|S|M @2000, t2 X|U @1000, t3 R|M @2000
      wr(2'd0, 32'd0); wr(2'd1, 32'h41); wr(2'd2, 32'h1000);
      wr(2'd0, 32'd1); wr(2'd1, 32'h5E); wr(2'd2, 32'h2000);
      wr(2'd0, 32'd2); wr(2'd1, 32'h09); wr(2'd2, 32'h1000);
      wr(2'd0, 32'd3); wr(2'd1, 32'h44); wr(2'd2, 32'h2000);

      // R4 R5 R10: vector table
      for (int i = 0; i < NV; i++) begin
         snoop(VEC[i][39], VEC[i][38:37], VEC[i][36:35], VEC[i][34:3],
               "R4 R5 R10 vector", VEC[i][2], VEC[i][1:0]);
      end

      // R2: read-back of enables, type field
      wr(2'd0, 32'd1);
      rd(2'd1, d); check("R2 ctrl readback", d, 32'h1000_005E);
      // R10: compare readback
      rd(2'd2, d); check("R10 cmp readback", d, 32'h0000_2000);
      // R6: trigger 1 unchanged after writes to other triggers
      rd(2'd0, d); check("R6 select", d, 32'd1);

      // R2: hypervisor bit dropped when unsupported
      wr(2'd0, 32'd3); wr(2'd1, 32'h64);
      rd(2'd1, d); check("R2 hyp dropped", d, 32'h1000_0044);

      // R3: match and action fields legalised to zero
      wr(2'd1, 32'h0007_FFC4);
      rd(2'd1, d); check("R3 fields zeroed", d, 32'h1000_0044);
      wr(2'd1, 32'h0FF8_0044);
      rd(2'd1, d); check("R3 upper bits zeroed", d, 32'h1000_0044);

      // R7: out-of-range select keeps index
      wr(2'd0, 32'd2);
      wr(2'd0, 32'd4);
      rd(2'd0, d); check("R7 select past end", d, 32'd2);
      wr(2'd0, 32'h7FFF_FFFF);
      rd(2'd0, d); check("R7 select far past end", d, 32'd2);

      // R8: mode bit stored separately
      wr(2'd0, 32'h8000_0001);
      rd(2'd0, d); check("R8 mode readback", d, 32'h8000_0001);
      rd(2'd1, d); check("R8 index unaffected", d, 32'h1000_005E);
      wr(2'd0, 32'h8000_0007);
      rd(2'd0, d); check("R8 mode with bad index", d, 32'h8000_0001);
      wr(2'd0, 32'h0000_0001);
      rd(2'd0, d); check("R8 mode cleared", d, 32'h0000_0001);

      // R10: unused address
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, d); check("R10 unused addr", d, 32'd0);
      rd(2'd1, d); check("R10 unused write no effect", d, 32'h1000_005E);

      // R9: zero disables t0; t2 still catches user exec, machine exec misses
      wr(2'd0, 32'd0); wr(2'd1, 32'd0);
      rd(2'd1, d); check("R9 ctrl cleared", d, 32'h1000_0000);
      snoop(1'b1, 2'd0, 2'd3, 32'h1000, "R9 disabled", 1'b0, 2'd0);
      snoop(1'b1, 2'd0, 2'd0, 32'h1000, "R9 other active", 1'b1, 2'd2);
      // R5: t1 disabled, load machine @2000 now goes to t3
      wr(2'd0, 32'd1); wr(2'd1, 32'd0);
      snoop(1'b1, 2'd2, 2'd3, 32'h2000, "R5 next lowest", 1'b1, 2'd3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule